// File: doc/BRIEF.md
# Machine Trap Cause Register

This block holds the machine-mode trap cause of a RISC-V-style core: a one-bit interrupt flag and a cause code below it. Two agents update it. The trap logic loads a new flag and code whenever a trap enters machine mode. Software writes it through a CSR port that carries an address, write data and a write strobe. Every software write is checked against a parameterised set of implemented interrupt codes and exception codes. A write that names a pair outside that set leaves the register untouched and raises an illegal-instruction fault.

A mode input selects a 32-bit or a 64-bit layout. The flag always sits in the top bit of the active width, and the code fills the bits beneath it. The stored value is read back on a 64-bit bus whenever the register's address is presented. The surrounding core supplies a machine-privilege indication. Trap prioritisation and pipeline control are handled outside this block.

Top module: `trap_cause_csr`

## Requirements
- R1: After reset the flag and the code are both 0, so a read of address 0x342 returns 0.
- R2: The register answers at CSR address 0x342. In 64-bit mode (`xlen64_i`=1) a read returns the flag in bit 63 and the code in bits 62:0. In 32-bit mode a read returns the flag in bit 31 and the code in bits 30:0, with bits 63:32 zero. Reads of any other address return 0.
- R3: When `trap_take_i` is high, the next clock edge stores `trap_irq_i` as the flag and `trap_code_i` as the code. The code is cut to 31 bits in 32-bit mode.
- R4: A legal software write stores the written flag and code. These come from bit 63 and bits 62:0 of `csr_wdata_i` in 64-bit mode, and from bit 31 and bits 30:0 in 32-bit mode, where bits 63:32 are ignored.
- R5: A write is legal only if its code is below 64 and its bit is set in `IRQ_MASK` (when the flag is 1) or in `EXC_MASK` (when the flag is 0). The default interrupt codes are 1, 3, 5, 7, 9 and 11. The default exception codes are 0 to 9, 11, 12, 13 and 15.
- R6: A software write to 0x342 with an illegal pair raises `illegal_o` combinationally in the same cycle, and the stored flag and code stay unchanged.
- R7: A software write to 0x342 while `priv_m_i` is 0 raises `illegal_o` and changes nothing.
- R8: When a trap load and a software write fall in the same cycle, the trap value is stored, the software data is discarded and `illegal_o` stays low.
- R9: A write strobe with an address other than 0x342 changes no state and never raises `illegal_o`.
- R10: While in 32-bit mode, code bits 62:31 are cleared in storage. After a return to 64-bit mode, the flag is read in bit 63 and those upper code bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xlen64_i | input | 1 | 1 selects the 64-bit layout, 0 the 32-bit layout |
| priv_m_i | input | 1 | Core is in machine privilege mode |
| trap_take_i | input | 1 | A trap enters machine mode this cycle |
| trap_irq_i | input | 1 | Trap is an asynchronous interrupt |
| trap_code_i | input | 63 | Cause code of the trap |
| csr_we_i | input | 1 | Software write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Software write data |
| csr_rdata_o | output | 64 | Read data for the presented address |
| illegal_o | output | 1 | Illegal-instruction fault for the current write |

## Verification
A hardware trap load and a software write can land in the same cycle. The bench provokes this in directed cases that pair a trap with an illegal write and with a legal write. It also raises `trap_take_i` at random about one cycle in five while random writes run. In every such cycle it expects `illegal_o` low, and it expects the next read to show the trap's flag and code rather than the written data. Mode switches are mixed into the same stream so that the collision is judged under both layouts.

// File: rtl/trap_cause_pkg.sv
package trap_cause_pkg;
  localparam int unsigned XLEN_MAX = 64;
  localparam int unsigned CODE_W   = XLEN_MAX - 1;
  localparam int unsigned CODE32_W = 31;
  localparam logic [11:0] CAUSE_ADDR = 12'h342;

  typedef struct packed {
    logic              irq;
    logic [CODE_W-1:0] code;
  } cause_t;
endpackage

// File: rtl/cause_rst_sync.sv
module cause_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cause_unpack.sv
module cause_unpack
  import trap_cause_pkg::*;
(
  input  logic                xlen64_i,
  input  logic [XLEN_MAX-1:0] wdata_i,
  output cause_t              fields_o
);
  always_comb begin
    if (xlen64_i) begin
      fields_o.irq  = wdata_i[XLEN_MAX-1];
      fields_o.code = wdata_i[CODE_W-1:0];
    end else begin
      fields_o.irq  = wdata_i[CODE32_W];
      fields_o.code = {{(CODE_W-CODE32_W){1'b0}}, wdata_i[CODE32_W-1:0]};
    end
  end
endmodule

// File: rtl/cause_legal.sv
module cause_legal
  import trap_cause_pkg::*;
#(
  parameter int unsigned MASK_W = 64,
  parameter logic [MASK_W-1:0] IRQ_MASK = 64'h0000_0000_0000_0AAA,
  parameter logic [MASK_W-1:0] EXC_MASK = 64'h0000_0000_0000_BBFF
) (
  input  cause_t cause_i,
  output logic   legal_o
);
  localparam int unsigned IDX_W = $clog2(MASK_W);

  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (cause_i.code[CODE_W-1:IDX_W] == '0);
  assign idx      = cause_i.code[IDX_W-1:0];

  always_comb begin
    if (!in_range)        legal_o = 1'b0;
    else if (cause_i.irq) legal_o = IRQ_MASK[idx];
    else                  legal_o = EXC_MASK[idx];
  end
endmodule

// File: rtl/cause_store.sv
module cause_store
  import trap_cause_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   xlen64_i,
  input  logic   load_i,
  input  cause_t load_val_i,
  output cause_t cause_qo
);
  cause_t cause_q;
  cause_t cause_d;
  logic   upper_dirty;
  logic   en;

  assign upper_dirty = |cause_q.code[CODE_W-1:CODE32_W];
  assign en          = load_i | (!xlen64_i & upper_dirty);

  always_comb begin
    cause_d = load_i ? load_val_i : cause_q;
    if (!xlen64_i) cause_d.code[CODE_W-1:CODE32_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cause_q <= '0;
    else if (en)  cause_q <= cause_d;
  end

  assign cause_qo = cause_q;
endmodule

// File: rtl/trap_cause_csr.sv
module trap_cause_csr
  import trap_cause_pkg::*;
#(
  parameter int unsigned MASK_W = 64,
  parameter logic [MASK_W-1:0] IRQ_MASK = 64'h0000_0000_0000_0AAA,
  parameter logic [MASK_W-1:0] EXC_MASK = 64'h0000_0000_0000_BBFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                xlen64_i,
  input  logic                priv_m_i,
  input  logic                trap_take_i,
  input  logic                trap_irq_i,
  input  logic [CODE_W-1:0]   trap_code_i,
  input  logic                csr_we_i,
  input  logic [11:0]         csr_addr_i,
  input  logic [XLEN_MAX-1:0] csr_wdata_i,
  output logic [XLEN_MAX-1:0] csr_rdata_o,
  output logic                illegal_o
);
  logic   rst_sync_n;
  cause_t wr_fields;
  logic   wr_legal;
  logic   addr_hit;
  logic   sw_hit;
  logic   sw_ok;
  logic   load;
  cause_t load_val;
  cause_t cause_q;

  cause_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  cause_unpack i_unpack (
    .xlen64_i (xlen64_i),
    .wdata_i  (csr_wdata_i),
    .fields_o (wr_fields)
  );

  cause_legal #(
    .MASK_W   (MASK_W),
    .IRQ_MASK (IRQ_MASK),
    .EXC_MASK (EXC_MASK)
  ) i_legal (
    .cause_i (wr_fields),
    .legal_o (wr_legal)
  );

  assign addr_hit  = (csr_addr_i == CAUSE_ADDR);
  assign sw_hit    = csr_we_i & addr_hit & !trap_take_i;
  assign sw_ok     = sw_hit & priv_m_i & wr_legal;
  assign illegal_o = sw_hit & (!priv_m_i | !wr_legal);

  assign load = trap_take_i | sw_ok;

  always_comb begin
    if (trap_take_i) begin
      load_val.irq  = trap_irq_i;
      load_val.code = trap_code_i;
    end else begin
      load_val = wr_fields;
    end
  end

  cause_store i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .xlen64_i   (xlen64_i),
    .load_i     (load),
    .load_val_i (load_val),
    .cause_qo   (cause_q)
  );

  always_comb begin
    if (!addr_hit)     csr_rdata_o = '0;
    else if (xlen64_i) csr_rdata_o = {cause_q.irq, cause_q.code};
    else               csr_rdata_o = {{(XLEN_MAX-CODE32_W-1){1'b0}}, cause_q.irq,
                                      cause_q.code[CODE32_W-1:0]};
  end
endmodule

// File: rtl/trap_cause_csr_chk.sv
module trap_cause_csr_chk
  import trap_cause_pkg::*;
(
  input logic                clk_i,
  input logic                rst_sync_n,
  input logic                xlen64_i,
  input logic                priv_m_i,
  input logic                trap_take_i,
  input logic                trap_irq_i,
  input logic [CODE_W-1:0]   trap_code_i,
  input logic                csr_we_i,
  input logic [11:0]         csr_addr_i,
  input logic [XLEN_MAX-1:0] csr_rdata_o,
  input logic                illegal_o,
  input cause_t              cause_q
);
  // R3: trap value lands on the next edge
  a_r3_trap_load: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    trap_take_i |=> (cause_q.irq == $past(trap_irq_i)) &&
                    (cause_q.code[CODE32_W-1:0] == $past(trap_code_i[CODE32_W-1:0])));

  // R6: a faulting write leaves the register unchanged
  a_r6_hold_on_fault: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    illegal_o && (xlen64_i || cause_q.code[CODE_W-1:CODE32_W] == '0) |=> $stable(cause_q));

  // R7: write outside machine mode faults
  a_r7_priv_fault: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    csr_we_i && csr_addr_i == CAUSE_ADDR && !priv_m_i && !trap_take_i |-> illegal_o);

  // R8: trap collision never faults
  a_r8_trap_wins: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    trap_take_i |-> !illegal_o);

  // R9: other addresses never fault
  a_r9_other_addr: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    csr_we_i && csr_addr_i != CAUSE_ADDR |-> !illegal_o);

  // R2: 32-bit layout keeps the upper read half zero
  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !xlen64_i |-> csr_rdata_o[XLEN_MAX-1:CODE32_W+1] == '0);

  // R10: 32-bit mode clears stored upper code bits
  a_r10_truncate: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !xlen64_i |=> cause_q.code[CODE_W-1:CODE32_W] == '0);
endmodule

bind trap_cause_csr trap_cause_csr_chk i_chk (.*);

// File: tb/test_trap_cause_csr.sv
`timescale 1ns/1ps
module test_trap_cause_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        xlen64_i;
  logic        priv_m_i;
  logic        trap_take_i;
  logic        trap_irq_i;
  logic [62:0] trap_code_i;
  logic        csr_we_i;
  logic [11:0] csr_addr_i;
  logic [63:0] csr_wdata_i;
  logic [63:0] csr_rdata_o;
  logic        illegal_o;

  int tests = 0;
  int fails = 0;
  logic        mf;
  logic [62:0] mc;

  localparam logic [63:0] IRQ_M = 64'h0AAA;
  localparam logic [63:0] EXC_M = 64'hBBFF;

  always #2.5 clk_i = ~clk_i;

  trap_cause_csr i_trap_cause_csr (.*);

  function automatic logic legal_f(input logic f, input logic [62:0] c);
    if (c >= 63'd64) return 1'b0;
    return f ? IRQ_M[c[5:0]] : EXC_M[c[5:0]];
  endfunction

  function automatic logic [63:0] read_f(input logic [11:0] a, input logic m);
    if (a != 12'h342) return 64'd0;
    return m ? {mf, mc} : {32'd0, mf, mc[30:0]};
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [11:0] addr, input logic [63:0] wd,
                    input logic priv, input logic trap, input logic tirq,
                    input logic [62:0] tcode, input logic mode, input string req);
    logic        wf;
    logic [62:0] wc;
    logic        hit;
    logic        exp_ill;
    @(negedge clk_i);
    csr_we_i = we; csr_addr_i = addr; csr_wdata_i = wd; priv_m_i = priv;
    trap_take_i = trap; trap_irq_i = tirq; trap_code_i = tcode; xlen64_i = mode;
    wf  = mode ? wd[63] : wd[31];
    wc  = mode ? wd[62:0] : {32'd0, wd[30:0]};
    hit = we && addr == 12'h342 && !trap;
    exp_ill = hit && (!priv || !legal_f(wf, wc));
    #1;
    check(illegal_o == exp_ill, {req, " fault"}, {63'd0, illegal_o}, {63'd0, exp_ill});
    @(posedge clk_i);
    if (trap) begin mf = tirq; mc = tcode; end
    else if (hit && !exp_ill) begin mf = wf; mc = wc; end
    if (!mode) mc[62:31] = '0;
    @(negedge clk_i);
    csr_we_i = 1'b0; trap_take_i = 1'b0; csr_addr_i = 12'h342;
    #1;
    check(csr_rdata_o == read_f(12'h342, mode), {req, " readback"},
          csr_rdata_o, read_f(12'h342, mode));
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; xlen64_i = 1'b1; priv_m_i = 1'b1; trap_take_i = 1'b0;
    trap_irq_i = 1'b0; trap_code_i = '0; csr_we_i = 1'b0; csr_addr_i = 12'h342;
    csr_wdata_i = '0; mf = 1'b0; mc = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    check(csr_rdata_o == 64'd0, "R1 reset value", csr_rdata_o, 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    check(csr_rdata_o == 64'd0, "R1 after release", csr_rdata_o, 64'd0);
    csr_addr_i = 12'h341; #1;
    check(csr_rdata_o == 64'd0, "R2 other address reads zero", csr_rdata_o, 64'd0);

    op(1, 12'h342, {1'b1, 63'd11}, 1, 0, 0, 0, 1, "R4 legal irq 11");
    op(1, 12'h342, {1'b1, 63'd2},  1, 0, 0, 0, 1, "R6 illegal irq 2");
    op(1, 12'h342, {1'b0, 63'd10}, 1, 0, 0, 0, 1, "R5 exc 10 undefined");
    op(1, 12'h342, {1'b0, 63'd15}, 1, 0, 0, 0, 1, "R5 exc 15 legal");
    op(1, 12'h342, {1'b1, 63'd65}, 1, 0, 0, 0, 1, "R5 code 65 out of range");
    op(1, 12'h342, {1'b1, 63'd3},  0, 0, 0, 0, 1, "R7 user-mode write");
    op(1, 12'h342, {1'b1, 63'd4},  1, 1, 1, 63'd7, 1, "R8 trap beats illegal write");
    op(1, 12'h342, {1'b0, 63'd2},  1, 1, 0, 63'd13, 1, "R8 trap beats legal write");
    op(1, 12'h305, {1'b1, 63'd5},  1, 0, 0, 0, 1, "R9 other address write");
    op(1, 12'h342, {32'hFFFF_0000, 1'b1, 31'd9}, 1, 0, 0, 0, 0, "R4 32-bit write");
    op(0, 12'h342, 64'd0, 1, 1, 0, 63'h100_0000_0005, 1, "R3 wide trap code");
    op(0, 12'h342, 64'd0, 1, 0, 0, 0, 0, "R10 switch to 32-bit");
    op(0, 12'h342, 64'd0, 1, 0, 0, 0, 1, "R10 back to 64-bit");

    for (int i = 0; i < 600; i++) begin
      logic [62:0] c;
      logic        f, m;
      logic [63:0] wd;
      logic [11:0] a;
      f = 1'($urandom);
      m = ($urandom % 8) != 0;
      c = ($urandom % 4 == 0) ? {$urandom, $urandom} : 63'($urandom % 20);
      wd = m ? {f, c} : {$urandom, f, c[30:0]};
      a = ($urandom % 8 == 0) ? 12'($urandom) : 12'h342;
      op(($urandom % 4) != 0, a, wd, ($urandom % 10) != 0, ($urandom % 5) == 0,
         1'($urandom), {$urandom, $urandom}, m, "R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule